// File: doc/BRIEF.md
# Control-Plane Exception Rate Limiter

This block sits on the path of packets being punted to the control processor. For each packet it reads the exception flags and header fields that an upstream parser has already extracted. It sorts the packet into one of five exception classes, and each class is policed by its own token bucket. A packet whose bucket holds a token goes on to the CPU queue and spends that token. A packet whose bucket is empty is dropped, and the drop counter for its class is incremented. A packet that carries no exception flag is passed through untouched.

Every bucket has a programmable refill rate and a programmable burst depth, loaded through a simple write port. A periodic `tick_i` strobe sets the refill cadence. The decision comes out one cycle after the packet is presented.

Top module: `exc_rate_limiter`

## Requirements
- R1: A packet is assigned to exactly one class by fixed priority. The class codes on `res_cls_o` are:
  - 0 (IP error): `csum_err_i` or `len_err_i`
  - 1 (TTL failure): `ttl_i` <= 1
  - 2 (MTU): `pkt_len_i` > `egress_mtu_i`
  - 3 (options): `ip_opts_i` and `unicast_i`
  - 4 (no route): `no_route_i`
- R2: A packet matching none of the R1 conditions (including multicast packets with options set) is reported with `res_exc_o`=0 and `res_pass_o`=1. It consumes no token and changes no counter.
- R3: The result of a packet presented with `pkt_valid_i` high appears on `res_*` with `res_valid_o`=1 exactly one clock later. `res_pass_o` and `res_drop_o` are never both high.
- R4: On each cycle with `tick_i` high, every bucket gains its class rate in tokens and saturates at its class burst depth.
- R5: A classified packet passes and spends one token if its bucket is non-empty. Otherwise it is dropped (`res_drop_o`=1).
- R6: When a packet and `tick_i` arrive in the same cycle, the decision uses the token count from before the refill, and the refill still applies.
- R7: Each class has a drop counter on `drop_cnt_o` (class c at bits c*CNT_W upward, CNT_W defaults to 32). The counter rises by one per dropped packet of that class and holds at all ones.
- R8: With `cfg_we_i` high, `cfg_rate_i` and `cfg_burst_i` are written to class `cfg_cls_i`. A bucket holding more tokens than a newly lowered burst is clamped to that burst on the next cycle.
- R9: After reset all tokens, rates, bursts and counters are zero and all `res_*` outputs are low. With rate zero, ticks add nothing.
- R10: The buckets are independent: draining or dropping in one class does not affect the decisions of another class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Refill strobe |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_cls_i | input | 3 | Class index of the write |
| cfg_rate_i | input | TOK_W | Tokens added per tick |
| cfg_burst_i | input | TOK_W | Bucket depth |
| pkt_valid_i | input | 1 | Packet descriptor valid |
| csum_err_i | input | 1 | IP checksum error |
| len_err_i | input | 1 | IP length error |
| ttl_i | input | 8 | Time-to-live field |
| pkt_len_i | input | LEN_W | Packet length |
| egress_mtu_i | input | LEN_W | Egress MTU |
| ip_opts_i | input | 1 | IP options present |
| unicast_i | input | 1 | Destination is unicast |
| no_route_i | input | 1 | Forwarding lookup missed |
| res_valid_o | output | 1 | Result valid |
| res_pass_o | output | 1 | Packet forwarded to CPU queue |
| res_drop_o | output | 1 | Packet dropped |
| res_exc_o | output | 1 | Packet was classified |
| res_cls_o | output | 3 | Class code (R1) |
| drop_cnt_o | output | 5*CNT_W | Per-class drop counters |

## Verification
The hardest case to reach is a bucket that is already empty receiving a packet in the very cycle a tick arrives. In that case the decision and the refill must not see each other. The stimulus first drains one class completely with back-to-back packets, then presents the next packet with `tick_i` raised in the same cycle. It then confirms both the drop and the refilled count with a follow-up packet. Counter saturation is reached by building the bench instance with a narrow `CNT_W`, so that a short run of drops hits all ones.

// File: rtl/exc_rl_pkg.sv
package exc_rl_pkg;
  localparam int NCLS  = 5;
  localparam int CLS_W = 3;
  typedef enum logic [CLS_W-1:0] {
    CLS_ERR  = 3'd0,
    CLS_TTL  = 3'd1,
    CLS_MTU  = 3'd2,
    CLS_OPT  = 3'd3,
    CLS_NORT = 3'd4
  } exc_cls_e;
endpackage

// File: rtl/exc_classifier.sv
module exc_classifier
  import exc_rl_pkg::*;
#(
  parameter int TTL_W = 8,
  parameter int LEN_W = 14
) (
  input  logic             csum_err_i,
  input  logic             len_err_i,
  input  logic [TTL_W-1:0] ttl_i,
  input  logic [LEN_W-1:0] pkt_len_i,
  input  logic [LEN_W-1:0] egress_mtu_i,
  input  logic             ip_opts_i,
  input  logic             unicast_i,
  input  logic             no_route_i,
  output logic             hit_o,
  output exc_cls_e         cls_o
);
  logic ttl_bad, mtu_bad, opt_bad;
  assign ttl_bad = ttl_i <= TTL_W'(1);
  assign mtu_bad = pkt_len_i > egress_mtu_i;
  assign opt_bad = ip_opts_i && unicast_i;

  // fixed priority, first match wins
  always_comb begin
    hit_o = 1'b1;
    cls_o = CLS_ERR;
    if (csum_err_i || len_err_i) cls_o = CLS_ERR;
    else if (ttl_bad)            cls_o = CLS_TTL;
    else if (mtu_bad)            cls_o = CLS_MTU;
    else if (opt_bad)            cls_o = CLS_OPT;
    else if (no_route_i)         cls_o = CLS_NORT;
    else                         hit_o = 1'b0;
  end

  // R1
  always_comb begin
    cls_range_chk: assert (!hit_o || (int'(cls_o) < NCLS));
  end
endmodule

// File: rtl/token_bucket.sv
module token_bucket #(
  parameter int TOK_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             cfg_we_i,
  input  logic [TOK_W-1:0] cfg_rate_i,
  input  logic [TOK_W-1:0] cfg_burst_i,
  input  logic             take_i,
  output logic             grant_o
);
  logic [TOK_W-1:0] tok_q, rate_q, burst_q, tok_d, after_take;
  logic [TOK_W:0]   sum;

  assign grant_o    = tok_q != '0;
  assign after_take = tok_q - TOK_W'(take_i && grant_o);
  assign sum        = {1'b0, after_take} + (tick_i ? {1'b0, rate_q} : '0);
  assign tok_d      = (sum > {1'b0, burst_q}) ? burst_q : sum[TOK_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tok_q   <= '0;
      rate_q  <= '0;
      burst_q <= '0;
    end else begin
      tok_q <= tok_d;
      if (cfg_we_i) begin
        rate_q  <= cfg_rate_i;
        burst_q <= cfg_burst_i;
      end
    end
  end

  // R4
  cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(burst_q) |-> tok_q <= burst_q);
  // R5
  no_gain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(tick_i) |-> tok_q <= $past(tok_q));
endmodule

// File: rtl/drop_counter.sv
module drop_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_o <= '0;
    else if (inc_i && ~&cnt_o)     cnt_o <= cnt_o + CNT_W'(1);
  end

  // R7
  step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == $past(cnt_o)) || (cnt_o == $past(cnt_o) + CNT_W'(1)));
  // R7
  sat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&$past(cnt_o)) |-> (&cnt_o));
endmodule

// File: rtl/exc_rate_limiter.sv
module exc_rate_limiter
  import exc_rl_pkg::*;
#(
  parameter int TOK_W = 8,
  parameter int CNT_W = 32,
  parameter int LEN_W = 14
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  tick_i,
  input  logic                  cfg_we_i,
  input  logic [CLS_W-1:0]      cfg_cls_i,
  input  logic [TOK_W-1:0]      cfg_rate_i,
  input  logic [TOK_W-1:0]      cfg_burst_i,
  input  logic                  pkt_valid_i,
  input  logic                  csum_err_i,
  input  logic                  len_err_i,
  input  logic [7:0]            ttl_i,
  input  logic [LEN_W-1:0]      pkt_len_i,
  input  logic [LEN_W-1:0]      egress_mtu_i,
  input  logic                  ip_opts_i,
  input  logic                  unicast_i,
  input  logic                  no_route_i,
  output logic                  res_valid_o,
  output logic                  res_pass_o,
  output logic                  res_drop_o,
  output logic                  res_exc_o,
  output logic [CLS_W-1:0]      res_cls_o,
  output logic [NCLS*CNT_W-1:0] drop_cnt_o
);
  logic     hit;
  exc_cls_e cls;
  logic [NCLS-1:0] take_v, grant_v;
  logic any_grant;

  exc_classifier #(.TTL_W(8), .LEN_W(LEN_W)) u_cls (
    .csum_err_i, .len_err_i, .ttl_i, .pkt_len_i, .egress_mtu_i,
    .ip_opts_i, .unicast_i, .no_route_i,
    .hit_o(hit), .cls_o(cls)
  );

  for (genvar c = 0; c < NCLS; c++) begin : g_cls
    logic sel;
    assign sel       = pkt_valid_i && hit && (cls == exc_cls_e'(c));
    assign take_v[c] = sel;

    token_bucket #(.TOK_W(TOK_W)) u_tb (
      .clk_i, .rst_ni, .tick_i,
      .cfg_we_i   (cfg_we_i && (cfg_cls_i == CLS_W'(c))),
      .cfg_rate_i, .cfg_burst_i,
      .take_i     (sel),
      .grant_o    (grant_v[c])
    );

    drop_counter #(.CNT_W(CNT_W)) u_dc (
      .clk_i, .rst_ni,
      .inc_i (sel && !grant_v[c]),
      .cnt_o (drop_cnt_o[c*CNT_W +: CNT_W])
    );
  end

  assign any_grant = |(take_v & grant_v);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      res_pass_o  <= 1'b0;
      res_drop_o  <= 1'b0;
      res_exc_o   <= 1'b0;
      res_cls_o   <= '0;
    end else begin
      res_valid_o <= pkt_valid_i;
      res_pass_o  <= pkt_valid_i && (!hit || any_grant);
      res_drop_o  <= pkt_valid_i && hit && !any_grant;
      res_exc_o   <= pkt_valid_i && hit;
      res_cls_o   <= (pkt_valid_i && hit) ? cls : '0;
    end
  end

  // R3
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o == $past(pkt_valid_i));
  // R3
  excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(res_pass_o && res_drop_o));
  // R2
  bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !res_exc_o) |-> res_pass_o);
endmodule

// File: tb/sim_exc_rate_limiter.sv
module sim_exc_rate_limiter;
  localparam int TOK_W = 8;
  localparam int CNT_W = 3;
  localparam int LEN_W = 14;
  localparam int NC    = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic tick = 0, cfg_we = 0, pv = 0, csum = 0, lerr = 0, opts = 0, uni = 0, nort = 0;
  logic [2:0] cfg_cls = 0;
  logic [TOK_W-1:0] cfg_rate = 0, cfg_burst = 0;
  logic [7:0] ttl = 64;
  logic [LEN_W-1:0] len = 100, mtu = 14'd1500;
  logic r_valid, r_pass, r_drop, r_exc;
  logic [2:0] r_cls;
  logic [NC*CNT_W-1:0] cnts;

  exc_rate_limiter #(.TOK_W(TOK_W), .CNT_W(CNT_W), .LEN_W(LEN_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .cfg_we_i(cfg_we), .cfg_cls_i(cfg_cls),
    .cfg_rate_i(cfg_rate), .cfg_burst_i(cfg_burst), .pkt_valid_i(pv),
    .csum_err_i(csum), .len_err_i(lerr), .ttl_i(ttl), .pkt_len_i(len),
    .egress_mtu_i(mtu), .ip_opts_i(opts), .unicast_i(uni), .no_route_i(nort),
    .res_valid_o(r_valid), .res_pass_o(r_pass), .res_drop_o(r_drop),
    .res_exc_o(r_exc), .res_cls_o(r_cls), .drop_cnt_o(cnts)
  );

  typedef struct packed {
    logic       csum; logic lerr; logic [7:0] ttl; logic [13:0] len;
    logic       opts; logic uni;  logic nort;
    logic       exc;  logic pass; logic [2:0] cls;
  } vec_t;

  // buckets all hold 2 tokens before this table runs
  localparam vec_t VECS [14] = '{
    '{1'b0,1'b0,8'd64,14'd100, 1'b0,1'b0,1'b0, 1'b0,1'b1,3'd0}, // clean
    '{1'b0,1'b0,8'd1, 14'd100, 1'b0,1'b0,1'b0, 1'b1,1'b1,3'd1}, // ttl=1
    '{1'b1,1'b0,8'd0, 14'd100, 1'b0,1'b0,1'b0, 1'b1,1'b1,3'd0}, // csum over ttl
    '{1'b0,1'b0,8'd64,14'd1600,1'b0,1'b0,1'b0, 1'b1,1'b1,3'd2}, // mtu
    '{1'b0,1'b0,8'd64,14'd100, 1'b1,1'b1,1'b0, 1'b1,1'b1,3'd3}, // opts ucast
    '{1'b0,1'b0,8'd64,14'd100, 1'b1,1'b0,1'b1, 1'b1,1'b1,3'd4}, // opts mcast + no route
    '{1'b0,1'b0,8'd64,14'd100, 1'b1,1'b0,1'b0, 1'b0,1'b1,3'd0}, // opts mcast only
    '{1'b0,1'b0,8'd2, 14'd100, 1'b0,1'b1,1'b0, 1'b0,1'b1,3'd0}, // ttl=2
    '{1'b0,1'b0,8'd1, 14'd1600,1'b1,1'b1,1'b1, 1'b1,1'b1,3'd1}, // ttl over mtu/opts
    '{1'b0,1'b0,8'd1, 14'd100, 1'b0,1'b0,1'b0, 1'b1,1'b0,3'd1}, // ttl empty -> drop
    '{1'b0,1'b1,8'd64,14'd100, 1'b0,1'b0,1'b0, 1'b1,1'b1,3'd0}, // len err
    '{1'b0,1'b1,8'd1, 14'd100, 1'b0,1'b0,1'b0, 1'b1,1'b0,3'd0}, // err empty -> drop
    '{1'b0,1'b0,8'd64,14'd1500,1'b0,1'b0,1'b0, 1'b0,1'b1,3'd0}, // len == mtu
    '{1'b0,1'b0,8'd64,14'd1600,1'b1,1'b1,1'b1, 1'b1,1'b1,3'd2}  // mtu over opts
  };

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int cnt_of(input int c);
    return int'(cnts[c*CNT_W +: CNT_W]);
  endfunction

  task automatic do_tick();
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
  endtask

  task automatic cfg(input int c, input int rate, input int burst);
    @(negedge clk);
    cfg_we = 1; cfg_cls = 3'(c); cfg_rate = TOK_W'(rate); cfg_burst = TOK_W'(burst);
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic send(input vec_t v, input logic tk);
    @(negedge clk);
    csum = v.csum; lerr = v.lerr; ttl = v.ttl; len = v.len;
    opts = v.opts; uni = v.uni; nort = v.nort; pv = 1; tick = tk;
    @(negedge clk);
    pv = 0; tick = 0; csum = 0; lerr = 0; ttl = 64; len = 100; opts = 0; uni = 0; nort = 0;
  endtask

  // one packet of each class, else clean
  function automatic vec_t pkt(input int c);
    vec_t v = '{1'b0,1'b0,8'd64,14'd100,1'b0,1'b0,1'b0,1'b0,1'b0,3'd0};
    case (c)
      0: v.csum = 1;
      1: v.ttl = 1;
      2: v.len = 1600;
      3: begin v.opts = 1; v.uni = 1; end
      4: v.nort = 1;
      default: ;
    endcase
    return v;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R3 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 valid", r_valid, 0); chk("R9 pass", r_pass, 0); chk("R9 drop", r_drop, 0);
    chk("R9 cnts", int'(cnts), 0);
    rst_n = 1;
    // R9: zero rate, tick adds nothing -> drop
    do_tick();
    send(pkt(1), 0);
    chk("R9 empty drop", r_drop, 1); chk("R9 cls", r_cls, 1);
    chk("R7 ttl cnt", cnt_of(1), 1);

    for (int c = 0; c < NC; c++) cfg(c, 2, 3);
    do_tick(); // all at 2

    foreach (VECS[i]) begin
      send(VECS[i], 0);
      chk($sformatf("R3 valid v%0d", i), r_valid, 1);
      chk($sformatf("R1 exc v%0d", i), r_exc, int'(VECS[i].exc));
      chk($sformatf("R5 pass v%0d", i), r_pass, int'(VECS[i].pass));
      chk($sformatf("R5 drop v%0d", i), r_drop, int'(VECS[i].exc && !VECS[i].pass));
      if (VECS[i].exc) chk($sformatf("R1 cls v%0d", i), r_cls, int'(VECS[i].cls));
    end
    // R2: bypass left counters alone; tokens: err0 ttl0 mtu0 opt1 nort1
    chk("R2 err cnt", cnt_of(0), 1); chk("R2 ttl cnt", cnt_of(1), 2);
    chk("R2 opt cnt", cnt_of(3), 0);

    // R4: refill by rate
    do_tick(); // err2 ttl2 mtu2 opt3 nort3
    send(pkt(1), 0); chk("R4 ttl p1", r_pass, 1);
    send(pkt(1), 0); chk("R4 ttl p2", r_pass, 1);
    send(pkt(1), 0); chk("R5 ttl empty", r_drop, 1);
    chk("R7 ttl cnt", cnt_of(1), 3);

    // R6: tick with packet on empty bucket
    send(pkt(1), 1);
    chk("R6 pre-refill drop", r_drop, 1);
    chk("R6 ttl cnt", cnt_of(1), 4);
    send(pkt(1), 0); chk("R6 refill applied", r_pass, 1);

    // R4: burst cap
    do_tick(); do_tick(); do_tick();
    for (int k = 0; k < 3; k++) begin
      send(pkt(2), 0); chk("R4 mtu within burst", r_pass, 1);
    end
    send(pkt(2), 0); chk("R4 mtu over burst", r_drop, 1);
    chk("R7 mtu cnt", cnt_of(2), 1);

    // R10: other class unaffected
    send(pkt(3), 0); chk("R10 opt pass", r_pass, 1);
    chk("R10 opt cnt", cnt_of(3), 0);

    // R8: lower burst clamps tokens (err holds 3)
    cfg(0, 2, 1);
    send(pkt(0), 0); chk("R8 clamp pass", r_pass, 1);
    send(pkt(0), 0); chk("R8 clamp drop", r_drop, 1);
    do_tick();
    send(pkt(0), 0); chk("R8 new burst pass", r_pass, 1);
    send(pkt(0), 0); chk("R8 new burst drop", r_drop, 1);
    chk("R7 err cnt", cnt_of(0), 3);

    // R7: saturation (nort holds 3)
    for (int k = 0; k < 3; k++) send(pkt(4), 0);
    for (int k = 0; k < 9; k++) send(pkt(4), 0);
    chk("R7 nort sat", cnt_of(4), 7);
    send(pkt(4), 0);
    chk("R7 nort hold", cnt_of(4), 7); chk("R7 drop at sat", r_drop, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule